// File: doc/BRIEF.md
# Stalling Streaming 2-D Convolution Core

This block convolves a square image of `IMG_DIM`×`IMG_DIM` unsigned 32-bit pixels with a square `KER_DIM`×`KER_DIM` kernel. Pixels arrive one per beat on a valid/ready input stream in raster order. The kernel weights are presented all at once on a flat bus. For every kernel-sized window that lies fully inside the image, the block emits one result on a valid/last output stream. There is no padding and the stride is one, so each frame yields `(IMG_DIM-KER_DIM+1)²` results. The beat carrying the last result of a frame is flagged with `out_last`.

The datapath is a chain of multiply-accumulate stages. Every incoming pixel is broadcast to all stages. Partial sums move from stage to stage, and between kernel rows they pass through short delay lines. The block holds no output storage, so a single step enable advances the whole pipeline, and the input is ready exactly when the downstream sink is ready. The final kernel tap combines the live input pixel with the registered chain. Because of this, a result leaves on the same beat that accepts the pixel completing its window. A synchronous soft reset returns the frame position and every partial sum to zero.

Top module: `sconv_stream_core`

## Requirements
- R1: `in_ready` equals `out_ready` in every cycle.
- R2: `out_valid` is high only when `in_valid` is high and the pixel on the input sits at row ≥ `KER_DIM-1` and column ≥ `KER_DIM-1` of the frame. Rows and columns are counted from 0 in raster order of accepted pixels. A full frame therefore yields `(IMG_DIM-KER_DIM+1)²` output beats.
- R3: On each valid beat for output position (r,c), `out_data` equals the sum over i,j in [0,`KER_DIM`) of pixel[r+i][c+j] × w[i·`KER_DIM`+j]. Weight w[g] is `kernel_w[g*32 +: 32]`, so weight 0 is the least significant word. The kernel is not flipped.
- R4: `out_last` is high only together with `out_valid`, and exactly on the beat whose input pixel is the final pixel (row and column `IMG_DIM-1`) of a frame.
- R5: A pixel is consumed only in a cycle where both `in_valid` and `out_ready` are high. In any other cycle the frame position and every pipeline register hold, so a stream with gaps and backpressure yields the same result sequence as an unbroken one.
- R6: After `soft_rst` has been high at a clock edge, the next accepted pixel is row 0, column 0 of a new frame, even if the reset aborted a frame part-way.
- R7: After the final pixel of a frame is accepted, the next accepted pixel starts a new frame at row 0, column 0, with no idle cycle needed.
- R8: Arithmetic is unsigned, and products and sums wrap modulo 2³².
- R9: While `soft_rst` is high, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| soft_rst | input | 1 | Synchronous active-high clear of position and pipeline |
| kernel_w | input | KER_DIM·KER_DIM·32 | Concatenated weights, weight 0 in the lowest word |
| in_valid | input | 1 | Input pixel present |
| in_data | input | 32 | Input pixel, unsigned |
| in_ready | output | 1 | Core can accept a pixel (mirrors `out_ready`) |
| out_valid | output | 1 | A window result is on `out_data` |
| out_data | output | 32 | Window result, unsigned, truncated to 32 bits |
| out_last | output | 1 | Final result of the frame |
| out_ready | input | 1 | Downstream sink can take a result |

## Verification
The assertions assume the weight bus stays constant for the whole of a frame, and that `soft_rst` is high at the first clock edge so the position counters start from a known value. The stimulus changes weights only between frames or under reset, holds reset for several edges at time zero, and changes all inputs on the falling edge. Gaps on `in_valid` and stalls on `out_ready` are drawn at random with a fixed seed. This produces long freezes at window positions, plus cycles where a result is present but not taken, within the valid/ready rules the core expects.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

    // Flags that the position tracker hands to the datapath top.
    typedef struct packed {
        logic valid;
        logic last;
    } win_flags_t;

    // Number of window results in one frame at unit stride.
    function automatic int unsigned results_per_frame(input int unsigned img, input int unsigned ker);
        return (img - ker + 1) * (img - ker + 1);
    endfunction

    // Extra partial-sum delay between the end of one kernel row and the next.
    function automatic int unsigned row_gap(input int unsigned img, input int unsigned ker);
        return img - ker;
    endfunction

endpackage

// File: rtl/sconv_mac_stage.sv
module sconv_mac_stage #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] pix,
    input  logic [DATA_W-1:0] wt,
    input  logic [DATA_W-1:0] sum_in,
    output logic [DATA_W-1:0] acc_out
);

    typedef struct packed {
        logic [DATA_W-1:0] prod;
        logic [DATA_W-1:0] psum;
    } mac_state_t;

    mac_state_t st_d, st_q;

    // Product and incoming partial sum are captured separately; the add
    // happens after the register so multiplier and adder sit in different paths.
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.prod = pix * wt;
            st_d.psum = sum_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign acc_out = st_q.prod + st_q.psum;

    // R5: a stage without a step keeps both registers
    p_mac_hold_r5: assert property (@(posedge clk) disable iff (clr)
        !en |=> $stable(st_q));

endmodule

// File: rtl/sconv_row_delay.sv
module sconv_row_delay #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN    = 5
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    generate
        if (LEN == 0) begin : g_direct
            assign dout = din;
        end else begin : g_line
            logic [DATA_W-1:0] line_d [LEN];
            logic [DATA_W-1:0] line_q [LEN];

            always_comb begin
                line_d = line_q;
                if (clr) begin
                    for (int t = 0; t < int'(LEN); t++) line_d[t] = '0;
                end else if (en) begin
                    line_d[0] = din;
                    for (int t = 1; t < int'(LEN); t++) line_d[t] = line_q[t-1];
                end
            end

            always_ff @(posedge clk) begin
                line_q <= line_d;
            end

            assign dout = line_q[LEN-1];

            // R5: the delay line is frozen whenever the pipeline stalls
            p_delay_hold_r5: assert property (@(posedge clk) disable iff (clr)
                !en |=> $stable(dout));
        end
    endgenerate

endmodule

// File: rtl/sconv_pos_tracker.sv
module sconv_pos_tracker
    import sconv_pkg::*;
#(
    parameter int unsigned IMG_DIM = 8,
    parameter int unsigned KER_DIM = 3
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       step,
    input  logic       in_valid,
    output win_flags_t flags
);

    localparam int unsigned CW = (IMG_DIM > 1) ? $clog2(IMG_DIM) : 1;
    localparam logic [CW-1:0] EDGE_IDX  = CW'(IMG_DIM - 1);
    localparam logic [CW-1:0] FIRST_WIN = CW'(KER_DIM - 1);

    typedef struct packed {
        logic [CW-1:0] row;
        logic [CW-1:0] col;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (clr) begin
            pos_d = '0;
        end else if (step) begin
            if (pos_q.col == EDGE_IDX) begin
                pos_d.col = '0;
                pos_d.row = (pos_q.row == EDGE_IDX) ? '0 : pos_q.row + 1'b1;
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    always_comb begin
        flags.valid = in_valid && !clr && (pos_q.row >= FIRST_WIN) && (pos_q.col >= FIRST_WIN);
        flags.last  = in_valid && !clr && (pos_q.row == EDGE_IDX) && (pos_q.col == EDGE_IDX);
    end

    // R5: no accepted pixel, no movement of the frame position
    p_tracker_hold_r5: assert property (@(posedge clk) disable iff (clr)
        !step |=> $stable(pos_q));

    // R7: accepting the final pixel brings the position home
    p_frame_wrap_r7: assert property (@(posedge clk) disable iff (clr)
        (step && flags.last) |=> (pos_q == '0));

    // R6: a soft reset edge leaves the position at the frame origin
    p_clear_home_r6: assert property (@(posedge clk)
        clr |=> (pos_q == '0));

endmodule

// File: rtl/sconv_stream_core.sv
module sconv_stream_core
    import sconv_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IMG_DIM = 8,
    parameter int unsigned KER_DIM = 3
) (
    input  logic                                  clk,
    input  logic                                  soft_rst,
    input  logic [KER_DIM*KER_DIM*DATA_W-1:0]     kernel_w,
    input  logic                                  in_valid,
    input  logic [DATA_W-1:0]                     in_data,
    output logic                                  in_ready,
    output logic                                  out_valid,
    output logic [DATA_W-1:0]                     out_data,
    output logic                                  out_last,
    input  logic                                  out_ready
);

    localparam int unsigned TAPS = KER_DIM * KER_DIM;
    localparam int unsigned GAP  = row_gap(IMG_DIM, KER_DIM);

    logic              step;
    win_flags_t        flags;
    logic [DATA_W-1:0] wt       [TAPS];
    logic [DATA_W-1:0] tap_acc  [TAPS-1];
    logic [DATA_W-1:0] tap_sum  [TAPS-1];
    logic [DATA_W-1:0] row_carry[KER_DIM-1];

    // Only downstream can stall; a pixel moves only if its result can too.
    assign in_ready = out_ready;
    assign step     = in_valid && out_ready && !soft_rst;

    genvar g;
    generate
        for (g = 0; g < int'(TAPS); g++) begin : g_wsplit
            assign wt[g] = kernel_w[g*DATA_W +: DATA_W];
        end

        // Registered stages 0 .. TAPS-2; the last tap uses the live pixel.
        for (g = 0; g < int'(TAPS) - 1; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign tap_sum[g] = '0;
            end else if ((g % int'(KER_DIM)) == 0) begin : g_rowstart
                assign tap_sum[g] = row_carry[g / int'(KER_DIM) - 1];
            end else begin : g_inrow
                assign tap_sum[g] = tap_acc[g-1];
            end

            sconv_mac_stage #(
                .DATA_W (DATA_W)
            ) u_mac (
                .clk     (clk),
                .clr     (soft_rst),
                .en      (step),
                .pix     (in_data),
                .wt      (wt[g]),
                .sum_in  (tap_sum[g]),
                .acc_out (tap_acc[g])
            );
        end

        for (g = 0; g < int'(KER_DIM) - 1; g++) begin : g_rowdly
            sconv_row_delay #(
                .DATA_W (DATA_W),
                .LEN    (GAP)
            ) u_dly (
                .clk  (clk),
                .clr  (soft_rst),
                .en   (step),
                .din  (tap_acc[g*int'(KER_DIM) + int'(KER_DIM) - 1]),
                .dout (row_carry[g])
            );
        end
    endgenerate

    sconv_pos_tracker #(
        .IMG_DIM (IMG_DIM),
        .KER_DIM (KER_DIM)
    ) u_pos (
        .clk      (clk),
        .clr      (soft_rst),
        .step     (step),
        .in_valid (in_valid),
        .flags    (flags)
    );

    assign out_data  = in_data * wt[TAPS-1] + tap_acc[TAPS-2];
    assign out_valid = flags.valid;
    assign out_last  = flags.last;

    // R2: a result never appears without an input pixel completing it
    p_valid_needs_input_r2: assert property (@(posedge clk) disable iff (soft_rst)
        out_valid |-> in_valid);

    // R4: end-of-frame flag only rides on a valid result
    p_last_implies_valid_r4: assert property (@(posedge clk) disable iff (soft_rst)
        out_last |-> out_valid);

    // R9: outputs stay quiet during soft reset
    p_rst_quiet_r9: assert property (@(posedge clk)
        soft_rst |-> (!out_valid && !out_last));

endmodule

// File: tb/sconv_stream_core_tb.sv
module sconv_stream_core_tb;

    localparam int N    = 8;
    localparam int K    = 3;
    localparam int DW   = 32;
    localparam int K2   = K * K;
    localparam int OUTS = (N - K + 1) * (N - K + 1);

    logic              clk = 1'b0;
    logic              soft_rst;
    logic [K2*DW-1:0]  wbus;
    logic              in_valid;
    logic [DW-1:0]     in_data;
    logic              in_ready;
    logic              out_valid;
    logic [DW-1:0]     out_data;
    logic              out_last;
    logic              out_ready;

    int tests    = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [DW-1:0] img [N*N];

    always #5 clk = ~clk;

    sconv_stream_core #(
        .DATA_W  (DW),
        .IMG_DIM (N),
        .KER_DIM (K)
    ) u_dut (
        .clk       (clk),
        .soft_rst  (soft_rst),
        .kernel_w  (wbus),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Correlation-order window sum, wrapping at 32 bits (R3, R8)
    function automatic logic [DW-1:0] win_sum(input int r, input int c);
        logic [DW-1:0] acc = '0;
        for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++)
                acc = acc + img[(r+i)*N + c + j] * wbus[(i*K+j)*DW +: DW];
        return acc;
    endfunction

    // Stream 'count' pixels of img; check every cycle at the ports.
    task automatic run_frame(input int gap_pct, input int stall_pct, input int count,
                             input string dreq);
        int got = 0;
        for (int p = 0; p < count; p++) begin
            bit taken = 1'b0;
            while (!taken) begin
                int row = p / N;
                int col = p % N;
                bit exp_v;
                bit exp_l;
                @(negedge clk);
                in_valid  = (($urandom % 100) >= gap_pct);
                in_data   = img[p];
                out_ready = (($urandom % 100) >= stall_pct);
                #1;
                chk(in_ready == out_ready, "R1", "in_ready mirror", {31'd0, in_ready}, {31'd0, out_ready});
                exp_v = in_valid && row >= K-1 && col >= K-1;
                exp_l = exp_v && (p == N*N-1);
                chk(out_valid == exp_v, in_valid ? "R2" : "R5", "out_valid", {31'd0, out_valid}, {31'd0, exp_v});
                chk(out_last == exp_l, "R4", "out_last", {31'd0, out_last}, {31'd0, exp_l});
                if (exp_v && out_ready) begin
                    chk(out_data == win_sum(row-K+1, col-K+1), dreq, "out_data",
                        out_data, win_sum(row-K+1, col-K+1));
                    got++;
                end
                taken = in_valid && out_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (count == N*N)
            chk(got == OUTS, "R2", "results per frame", DW'(got), DW'(OUTS));
    endtask

    task automatic load_ramp();
        for (int p = 0; p < N*N; p++) img[p] = DW'(p);
        for (int g = 0; g < K2; g++) wbus[g*DW +: DW] = DW'(g);
    endtask

    task automatic load_random(input bit wide);
        for (int p = 0; p < N*N; p++) img[p] = wide ? $urandom : ($urandom % 256);
        for (int g = 0; g < K2; g++) wbus[g*DW +: DW] = wide ? $urandom : ($urandom % 16);
    endtask

    initial begin
        int seed = 32'h5eed_c0de;
        void'($urandom(seed));
        soft_rst  = 1'b1;
        in_valid  = 1'b0;
        in_data   = '0;
        out_ready = 1'b0;
        wbus      = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b0, "R1", "reset in_ready", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1; out_ready = 1'b1; #1;
        chk(out_valid == 1'b0 && out_last == 1'b0, "R9", "outputs in reset",
            {30'd0, out_valid, out_last}, 32'd0);
        @(negedge clk);
        soft_rst = 1'b0; in_valid = 1'b0;

        // Directed ramp, unbroken, then immediately again (R3, R7)
        load_ramp();
        run_frame(0, 0, N*N, "R3");
        run_frame(0, 0, N*N, "R7");

        // Gaps and backpressure (R5)
        load_random(1'b0);
        run_frame(30, 30, N*N, "R5");
        run_frame(60, 10, N*N, "R5");
        run_frame(10, 60, N*N, "R5");

        // Full-range values wrap modulo 2^32 (R8)
        for (int p = 0; p < N*N; p++) img[p] = 32'hFFFF_FFFF - DW'(p);
        for (int g = 0; g < K2; g++) wbus[g*DW +: DW] = 32'hFFFF_FFFF;
        run_frame(20, 20, N*N, "R8");
        load_random(1'b1);
        run_frame(40, 40, N*N, "R8");

        // Aborted frame then soft reset (R6, R9)
        load_random(1'b0);
        run_frame(20, 20, 30, "R3");
        @(negedge clk);
        soft_rst = 1'b1; in_valid = 1'b1; out_ready = 1'b1; #1;
        chk(out_valid == 1'b0, "R9", "out_valid under reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        soft_rst = 1'b0; in_valid = 1'b0;
        load_random(1'b0);
        run_frame(25, 25, N*N, "R6");

        for (int f = 0; f < 4; f++) begin
            load_random(f[0]);
            run_frame(int'($urandom % 50), int'($urandom % 50), N*N, "R3");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            failures++;
            $display("FAIL watchdog expired before completion");
            $display("[TB] %0d tests run, %0d failed", tests, failures);
            $finish;
        end
    end

endmodule